// File: doc/BRIEF.md
# Threshold-Driven FIFO Service Interrupt

This block is a 16-entry, byte-wide first-in first-out buffer that sits on a parallel-port data path between a host and a peripheral. A direction input chooses which side fills the buffer. When the data flows toward the peripheral, the host fills the buffer and the peripheral drains it. When the data flows toward the host, the peripheral fills it and the host drains it. The side that is not allowed to push or pop in the current direction is ignored.

A programmable threshold decides when the host is asked to service the buffer. When data flows toward the host, a request is raised once enough bytes are waiting that a burst of reads cannot underflow. When data flows toward the peripheral, a request is raised once enough space is free that a burst of writes cannot overflow. Each request is gated by a service bit. A request sets the service bit and pulses the interrupt output for one cycle. The host re-arms the block by writing the service bit back to zero.

The occupancy level and the full and empty flags are visible at all times.

Top module: `pp_fifo_svc_irq`

## Requirements
- R1: `level` reports the number of bytes held, from 0 to 16. `full` is 1 exactly when `level` is 16 and `empty` is 1 exactly when `level` is 0, in the same cycle. After reset, `level` is 0, `empty` is 1, `svc` is 1 and `irq` is 0.
- R2: Bytes leave in the order they entered. `rd_data` always shows the oldest byte held. A push while full is ignored and leaves `level` and the contents unchanged. A pop while empty is ignored.
- R3: A push and a pop in the same cycle leave `level` unchanged when the buffer is neither full nor empty. When full, only the pop takes effect (16 becomes 15). When empty, only the push takes effect (0 becomes 1).
- R4: With the registered direction at 1 (toward host), the peripheral pushes (`per_wr`) and the host pops (`host_rd`). The request condition is `level` >= 16 − T, where T is the effective threshold.
- R5: With the registered direction at 0 (toward peripheral), the host pushes (`host_wr`) and the peripheral pops (`per_rd`). The request condition is `level` <= T.
- R6: The effective threshold T equals `thresh` for values 0 to 14. Any value of 15 or more, including 16, acts as 15.
- R7: Suppose `svc` is 0, the request condition holds and `svc_we` is 0. Then at the next clock edge `svc` becomes 1 and `irq` is 1 for exactly that one cycle. No further `irq` occurs while `svc` stays 1.
- R8: With `svc_we` at 1, `svc` takes `svc_wd` at the next edge. This write overrides a request in the same cycle: no `irq` occurs and `svc` holds the written value.
- R9: The `to_host` input is registered. Push and pop roles and the comparison switch one cycle after it changes, and the buffered contents are kept across the switch.
- R10: At the moment of a request, the host can complete a burst of 16 − T operations in the requested direction without underflow or overflow. This means 16 − T pops toward host, or 16 − T pushes toward peripheral.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| to_host | input | 1 | Data direction: 1 peripheral-to-host, 0 host-to-peripheral |
| thresh | input | 5 | Service threshold (15 and above act as 15) |
| host_wr | input | 1 | Host push strobe |
| host_din | input | 8 | Host push data |
| host_rd | input | 1 | Host pop strobe |
| per_wr | input | 1 | Peripheral push strobe |
| per_din | input | 8 | Peripheral push data |
| per_rd | input | 1 | Peripheral pop strobe |
| rd_data | output | 8 | Oldest byte held |
| svc_we | input | 1 | Service bit write strobe |
| svc_wd | input | 1 | Service bit write value |
| svc | output | 1 | Service bit |
| irq | output | 1 | One-cycle service interrupt |
| level | output | 5 | Bytes held |
| full | output | 1 | Buffer holds 16 bytes |
| empty | output | 1 | Buffer holds no bytes |

## Verification
The hardest case to reach from the ports is a host write to the service bit landing in the same cycle as a live request. A live request turns the bit back to 1 on the very next edge, so the collision exists for a single cycle only. The stimulus first loads the buffer while the bit is masked and then writes 0 to re-arm it. On the immediately following cycle it writes 1 again, and the bench checks that no interrupt appears. A second narrow case is a push issued in the same cycle as a direction change. That push must still follow the old roles, because the direction is registered.

// File: rtl/fsi_pkg.sv
package fsi_pkg;

  typedef enum logic {
    DIR_TO_PER  = 1'b0,
    DIR_TO_HOST = 1'b1
  } fsi_dir_e;

  // Clamp the programmed threshold: depth and depth-1 are the same setting.
  function automatic int unsigned fsi_eff_thr(int unsigned thr, int unsigned depth);
    return (thr >= depth - 1) ? depth - 1 : thr;
  endfunction

  // Service request condition for a given direction, occupancy and threshold.
  function automatic logic fsi_want(logic to_host, int unsigned lvl,
                                    int unsigned thr_eff, int unsigned depth);
    if (to_host) return (lvl + thr_eff >= depth);
    return (lvl <= thr_eff);
  endfunction

endpackage

// File: rtl/fsi_store.sv
module fsi_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] lvl,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (lvl == CW'(DEPTH));
  assign empty   = (lvl == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      unique case ({push_ok, pop_ok})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
    end
  end

  // R1: occupancy never exceeds the depth
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= CW'(DEPTH));
  // R2: a lone push into a full buffer changes nothing
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(lvl)));
  // R2: a lone pop from an empty buffer changes nothing
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
  // R3: a simultaneous push and pop in the middle keeps the level
  a_r3_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(lvl));

endmodule

// File: rtl/fsi_thresh.sv
module fsi_thresh
  import fsi_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_in,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] lvl,
  output fsi_dir_e      dir_q,
  output logic          req
);

  int unsigned thr_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= DIR_TO_PER;
    else        dir_q <= fsi_dir_e'(dir_in);
  end

  always_comb begin
    thr_eff = fsi_eff_thr(32'(thr), DEPTH);
    req     = fsi_want(dir_q == DIR_TO_HOST, 32'(lvl), thr_eff, DEPTH);
  end

  // R4: a toward-host request always leaves bytes to read
  a_r4_rd_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_TO_HOST && req) |-> (lvl != '0));
  // R5: a toward-peripheral request always leaves room to write
  a_r5_wr_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_TO_PER && req) |-> (lvl != CW'(DEPTH)));

endmodule

// File: rtl/fsi_svc.sv
module fsi_svc (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic svc_we,
  input  logic svc_wd,
  output logic svc_q,
  output logic irq
);

  logic set_evt;

  assign set_evt = req && !svc_q && !svc_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      svc_q <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= set_evt;
      if (svc_we)       svc_q <= svc_wd;
      else if (set_evt) svc_q <= 1'b1;
    end
  end

  // R7: an interrupt only follows an armed service bit and leaves it set
  a_r7_irq_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (svc_q && !$past(svc_q)));
  // R7: the interrupt lasts one cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: a set service bit stays set until the host writes it
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !svc_we) |=> svc_q);
  // R8: a host write always lands
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    svc_we |=> (svc_q == $past(svc_wd) && !irq));

endmodule

// File: rtl/pp_fifo_svc_irq.sv
module pp_fifo_svc_irq
  import fsi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          to_host,
  input  logic [CW-1:0] thresh,
  input  logic          host_wr,
  input  logic [DW-1:0] host_din,
  input  logic          host_rd,
  input  logic          per_wr,
  input  logic [DW-1:0] per_din,
  input  logic          per_rd,
  output logic [DW-1:0] rd_data,
  input  logic          svc_we,
  input  logic          svc_wd,
  output logic          svc,
  output logic          irq,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);

  fsi_dir_e      dir_q;
  logic          req;
  logic          push, pop;
  logic [DW-1:0] push_data;

  // R9: side roles follow the registered direction
  always_comb begin
    if (dir_q == DIR_TO_HOST) begin
      push      = per_wr;
      push_data = per_din;
      pop       = host_rd;
    end else begin
      push      = host_wr;
      push_data = host_din;
      pop       = per_rd;
    end
  end

  fsi_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(push_data),
    .dout(rd_data), .lvl(level), .full(full), .empty(empty)
  );

  fsi_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk(clk), .rst_n(rst_n), .dir_in(to_host), .thr(thresh),
    .lvl(level), .dir_q(dir_q), .req(req)
  );

  fsi_svc u_svc (
    .clk(clk), .rst_n(rst_n), .req(req), .svc_we(svc_we),
    .svc_wd(svc_wd), .svc_q(svc), .irq(irq)
  );

  // R10: at an interrupt the requested burst fits
  a_r10_burst_fits: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (dir_q == DIR_TO_HOST ? !empty : !full));

endmodule

// File: tb/test_pp_fifo_svc_irq.sv
module test_pp_fifo_svc_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       to_host = 1'b0;
  logic [4:0] thresh = 5'd12;
  logic       host_wr = 0, host_rd = 0, per_wr = 0, per_rd = 0;
  logic [7:0] host_din = 0, per_din = 0;
  logic [7:0] rd_data;
  logic       svc_we = 0, svc_wd = 0;
  logic       svc, irq, full, empty;
  logic [4:0] level;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #10 clk = ~clk;

  pp_fifo_svc_irq i_pp_fifo_svc_irq (
    .clk(clk), .rst_n(rst_n), .to_host(to_host), .thresh(thresh),
    .host_wr(host_wr), .host_din(host_din), .host_rd(host_rd),
    .per_wr(per_wr), .per_din(per_din), .per_rd(per_rd),
    .rd_data(rd_data), .svc_we(svc_we), .svc_wd(svc_wd),
    .svc(svc), .irq(irq), .level(level), .full(full), .empty(empty)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(string req, int act, int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic hpush(logic [7:0] v);
    host_wr = 1; host_din = v; cyc(); host_wr = 0;
  endtask
  task automatic hpop();
    host_rd = 1; cyc(); host_rd = 0;
  endtask
  task automatic ppush(logic [7:0] v);
    per_wr = 1; per_din = v; cyc(); per_wr = 0;
  endtask
  task automatic ppop();
    per_rd = 1; cyc(); per_rd = 0;
  endtask
  task automatic svc_write(logic v);
    svc_we = 1; svc_wd = v; cyc(); svc_we = 0;
  endtask

  // independent restatement of the request rule
  function automatic bit bench_want(bit dir_h, int lvl, int thr);
    int t = (thr > 15) ? 15 : thr;
    if (dir_h) return (16 - lvl) <= t;
    return (16 - lvl) >= (16 - t);
  endfunction

  task automatic t_reset();
    to_host = 0;
    do_reset();
    chk_eq("R1 reset level", int'(level), 0);
    chk_eq("R1 reset empty", int'(empty), 1);
    chk_eq("R1 reset full", int'(full), 0);
    chk_eq("R1 reset svc", int'(svc), 1);
    chk_eq("R1 reset irq", int'(irq), 0);
  endtask

  task automatic t_order();
    to_host = 0;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      hpush(8'(i * 7 + 3));
      chk_eq("R1 level count", int'(level), i + 1);
    end
    chk_eq("R1 full flag", int'(full), 1);
    chk_eq("R1 empty clear", int'(empty), 0);
    hpush(8'hEE);
    chk_eq("R2 push when full ignored", int'(level), 16);
    for (int i = 0; i < 16; i++) begin
      chk_eq("R2 order", int'(rd_data), (i * 7 + 3) & 255);
      ppop();
    end
    chk_eq("R1 empty flag", int'(empty), 1);
    ppop();
    chk_eq("R2 pop when empty ignored", int'(level), 0);
  endtask

  task automatic t_simul();
    to_host = 0;
    do_reset();
    hpush(8'hA1); hpush(8'hA2); hpush(8'hA3);
    host_wr = 1; host_din = 8'hA4; per_rd = 1; cyc(); host_wr = 0; per_rd = 0;
    chk_eq("R3 push+pop keeps level", int'(level), 3);
    chk_eq("R3 push+pop head", int'(rd_data), 8'hA2);
    for (int i = 0; i < 13; i++) hpush(8'(i));
    chk_eq("R3 filled", int'(level), 16);
    host_wr = 1; host_din = 8'h55; per_rd = 1; cyc(); host_wr = 0; per_rd = 0;
    chk_eq("R3 full push+pop", int'(level), 15);
    do_reset();
    host_wr = 1; host_din = 8'h5A; per_rd = 1; cyc(); host_wr = 0; per_rd = 0;
    chk_eq("R3 empty push+pop", int'(level), 1);
    chk_eq("R3 empty push+pop data", int'(rd_data), 8'h5A);
  endtask

  task automatic t_read_thr();
    to_host = 1; thresh = 5'd12;
    do_reset();
    ppush(8'h10); ppush(8'h11); ppush(8'h12);
    svc_write(0);
    chk_eq("R8 re-arm", int'(svc), 0);
    cyc(); cyc();
    chk_eq("R4 below 16-T no irq", int'(irq), int'(bench_want(1, 3, 12)));
    ppush(8'h13);
    chk_eq("R4 level at 4", int'(level), 4);
    chk_eq("R7 irq not yet", int'(irq), 0);
    cyc();
    chk_eq("R4 irq at 16-T", int'(irq), int'(bench_want(1, 4, 12)));
    chk_eq("R7 svc set", int'(svc), 1);
    cyc();
    chk_eq("R7 irq one cycle", int'(irq), 0);
    for (int i = 0; i < 4; i++) begin
      chk_eq("R10 read burst data", int'(rd_data), 16 + i);
      hpop();
    end
    chk_eq("R10 read burst drained", int'(empty), 1);
  endtask

  task automatic t_write_thr();
    to_host = 0; thresh = 5'd12;
    do_reset();
    for (int i = 0; i < 13; i++) hpush(8'(i));
    svc_write(0);
    cyc();
    chk_eq("R5 above T no irq", int'(irq), 0);
    ppop();
    chk_eq("R5 level 12", int'(level), 12);
    cyc();
    chk_eq("R5 irq at T", int'(irq), int'(bench_want(0, 12, 12)));
    for (int i = 0; i < 4; i++) hpush(8'h80);
    chk_eq("R10 write burst fits", int'(level), 16);
    chk_eq("R10 write burst full", int'(full), 1);
  endtask

  task automatic t_alias_svc();
    int thr_list[4] = '{15, 16, 31, 14};
    foreach (thr_list[k]) begin
      to_host = 1; thresh = 5'(thr_list[k]);
      do_reset();
      ppush(8'h77);
      svc_write(0);
      cyc();
      chk_eq("R6 read alias", int'(irq), int'(bench_want(1, 1, thr_list[k])));
    end
    // write direction: 16 acts as 15, so a full buffer makes no request
    to_host = 0; thresh = 5'd16;
    do_reset();
    for (int i = 0; i < 16; i++) hpush(8'(i));
    svc_write(0);
    cyc();
    chk_eq("R6 write alias full", int'(irq), 0);
    ppop();
    cyc();
    chk_eq("R6 write alias 15", int'(irq), 1);
    // R7: held condition does not repeat the interrupt
    cyc(); cyc();
    chk_eq("R7 no repeat", int'(irq), 0);
    svc_write(0);
    cyc();
    chk_eq("R8 re-arm fires again", int'(irq), 1);
    // R8: write of 1 collides with a live request
    svc_write(0);
    svc_we = 1; svc_wd = 1; cyc(); svc_we = 0;
    chk_eq("R8 write overrides irq", int'(irq), 0);
    chk_eq("R8 write value kept", int'(svc), 1);
    cyc();
    chk_eq("R8 no late irq", int'(irq), 0);
  endtask

  task automatic t_dir();
    to_host = 0;
    do_reset();
    hpush(8'h11); hpush(8'h22);
    to_host = 1; host_wr = 1; host_din = 8'h33; cyc(); host_wr = 0;
    chk_eq("R9 push in switch cycle uses old role", int'(level), 3);
    hpush(8'h44);
    chk_eq("R9 host push ignored toward host", int'(level), 3);
    ppop();
    chk_eq("R9 peripheral pop ignored toward host", int'(level), 3);
    chk_eq("R9 contents kept", int'(rd_data), 8'h11);
    hpop();
    chk_eq("R9 host pops toward host", int'(level), 2);
    chk_eq("R9 next byte", int'(rd_data), 8'h22);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_simul();
    t_read_thr();
    t_write_thr();
    t_alias_svc();
    t_dir();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule